// File: doc/BRIEF.md
# Quad-rate burst SRAM model

A synthesizable behavioural model of a small synchronous SRAM with separate read and write data ports. Its purpose is to act as a memory target in controller testbenches. The model runs from one internal clock, `clk`, at twice the input clock rate. Each tick of `clk` stands for one half-cycle. Ticks alternate between the rising edge of the true input clock (the "K tick") and the rising edge of its complement (the "K-bar tick"). The echo clock output `cq` shows which one comes next: `cq` is low just before a K tick.

Every access is a burst of four words taken from a four-word group, so each address moves four data beats. A read command is taken on a K tick and a write command on a K-bar tick. Reads and writes are tracked independently and may overlap. Read data leaves through a latency pipeline of either four or five ticks, chosen at build time. It is flagged by `rvalid` and accompanied by the echo clocks.

A stop input freezes the model, the way a halted input clock would. After the clock resumes, the model holds `ready` low and refuses new commands for a recovery period.

Top module: `qdr_burst_sram`

## Requirements
- R1: `baddr` selects a group of four words. A burst touches the word offsets 0, 1, 2, 3 of that group, in that order, one per tick.
- R2: A read command (`rd_n` low) is honoured only on a K tick (`cq` low before the edge). A write command (`wr_n` low) is honoured only on a K-bar tick (`cq` high before the edge). A select asserted on the other tick has no effect.
- R3: After a write command taken at edge W, the value on `wdata` at edges W+1 to W+4 is stored into offsets 0 to 3. No other strobe is needed.
- R4: For a read command taken at edge T, word offset i appears on `rdata` after edge T+L+i. L is 4 ticks when `HALF_EXTRA` is 0 (2.0 cycles) and 5 ticks when it is 1 (2.5 cycles).
- R5: `rvalid` is high after exactly those four edges of each read burst and low otherwise.
- R6: `cq` toggles on every running tick, and `cq_n` is always its complement. Both are 0/1 after reset.
- R7: Read and write bursts proceed concurrently. A new command of a type is taken on the last beat of the previous burst of that type, so bursts can run back to back.
- R8: A command of a type that arrives while a burst of the same type is active, before its last beat, is ignored.
- R9: A read taken one tick after a write command to the same group returns the newly written words.
- R10: While `k_stop` is high, the model freezes and `ready` drops. After release, `ready` returns after 2*`RECOVER_K` ticks. Commands seen while `ready` is low are ignored.
- R11: After reset, `rvalid` is 0, `ready` is 1 and `cq` is 0.
- R12: The data width is the parameter `DW` (for example 9, 18 or 36). All bits are stored and returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle tick clock (twice the input clock rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| k_stop | input | 1 | High while the input clock is halted |
| rd_n | input | 1 | Active-low read select |
| wr_n | input | 1 | Active-low write select |
| baddr | input | AW-2 | Burst group address |
| wdata | input | DW | Write data beat |
| rdata | output | DW | Read data beat |
| rvalid | output | 1 | High while a read beat is driven |
| cq | output | 1 | Echo clock, low before a K tick |
| cq_n | output | 1 | Complementary echo clock |
| ready | output | 1 | Low during clock-stop recovery |

## Verification
Read beat i of a command taken at edge T is due after edge T+4+i, or T+5+i for the longer latency. A write beat is visible to a read fetch one tick after it was sampled. `ready` returns 2*`RECOVER_K` ticks after the stop is released, and `cq` flips on every running tick. The bench keeps an expected-read table keyed by the tick number at which each beat is due. It samples every output 1 ns after each edge and compares `rvalid`, `rdata`, `cq` and `ready` against that table at that tick. Latency and recovery length are also measured directly, as tick counts from the command or the release.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
    localparam int BEATS = 4;
    typedef logic [1:0] beat_t;
    localparam beat_t FIRST_BEAT = 2'd0;
    localparam beat_t LAST_BEAT  = 2'd3;
endpackage

// File: rtl/qdr_array.sv
module qdr_array #(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/qdr_rd_pipe.sv
module qdr_rd_pipe #(
    parameter int DW    = 18,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          in_v,
    input  logic [DW-1:0] in_d,
    output logic          out_v,
    output logic [DW-1:0] out_d
);
    typedef struct packed {
        logic [DEPTH-1:0]         v;
        logic [DEPTH-1:0][DW-1:0] d;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        if (en) begin
            pipe_d.v[0] = in_v;
            pipe_d.d[0] = in_d;
            for (int i = 1; i < DEPTH; i++) begin
                pipe_d.v[i] = pipe_q.v[i-1];
                pipe_d.d[i] = pipe_q.d[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_v = pipe_q.v[DEPTH-1];
    assign out_d = pipe_q.d[DEPTH-1];
endmodule

// File: rtl/qdr_wake.sv
module qdr_wake #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic k_stop,
    output logic ready
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] FULL = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (k_stop) begin
            cnt_d = '0;
        end else if (cnt_q != FULL) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= FULL;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ready = (cnt_q == FULL);
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
    parameter int DW         = 18,
    parameter int AW         = 6,
    parameter int HALF_EXTRA = 0,
    parameter int RECOVER_K  = 2048
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          k_stop,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-3:0] baddr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          cq,
    output logic          cq_n,
    output logic          ready
);
    import qdr_pkg::*;

    localparam int BW         = AW - 2;
    localparam int LAT_TICKS  = 4 + HALF_EXTRA;
    localparam int WAKE_TICKS = 2 * RECOVER_K;

    typedef struct packed {
        logic          phase;
        logic          rd_act;
        beat_t         rd_cnt;
        logic [BW-1:0] rd_base;
        logic          wr_act;
        beat_t         wr_cnt;
        logic [BW-1:0] wr_base;
    } seq_t;

    seq_t          st_d, st_q;
    logic          run, rd_take, wr_take, fetch_v, wr_en;
    logic [AW-1:0] fetch_addr, wr_addr;
    logic [DW-1:0] fetch_data;
    logic          rd_busy, wr_busy;
    beat_t         wr_beat;

    always_comb begin
        st_d       = st_q;
        run        = !k_stop;
        rd_take    = run && ready && !st_q.phase && !rd_n &&
                     (!st_q.rd_act || st_q.rd_cnt == LAST_BEAT);
        wr_take    = run && ready && st_q.phase && !wr_n &&
                     (!st_q.wr_act || st_q.wr_cnt == LAST_BEAT);
        fetch_v    = run && st_q.rd_act;
        fetch_addr = {st_q.rd_base, st_q.rd_cnt};
        wr_en      = run && st_q.wr_act;
        wr_addr    = {st_q.wr_base, st_q.wr_cnt};
        if (run) begin
            st_d.phase = !st_q.phase;
            if (st_q.rd_act) begin
                st_d.rd_cnt = st_q.rd_cnt + 1'b1;
                if (st_q.rd_cnt == LAST_BEAT) st_d.rd_act = 1'b0;
            end
            if (rd_take) begin
                st_d.rd_act  = 1'b1;
                st_d.rd_cnt  = FIRST_BEAT;
                st_d.rd_base = baddr;
            end
            if (st_q.wr_act) begin
                st_d.wr_cnt = st_q.wr_cnt + 1'b1;
                if (st_q.wr_cnt == LAST_BEAT) st_d.wr_act = 1'b0;
            end
            if (wr_take) begin
                st_d.wr_act  = 1'b1;
                st_d.wr_cnt  = FIRST_BEAT;
                st_d.wr_base = baddr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cq      = st_q.phase;
    assign cq_n    = !st_q.phase;
    assign rd_busy = st_q.rd_act;
    assign wr_busy = st_q.wr_act;
    assign wr_beat = st_q.wr_cnt;

    qdr_array #(.DW(DW), .AW(AW)) u_array (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wdata),
        .raddr (fetch_addr),
        .rdata (fetch_data)
    );

    qdr_rd_pipe #(.DW(DW), .DEPTH(LAT_TICKS)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .in_v  (fetch_v),
        .in_d  (fetch_data),
        .out_v (rvalid),
        .out_d (rdata)
    );

    qdr_wake #(.LIMIT(WAKE_TICKS)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .k_stop (k_stop),
        .ready  (ready)
    );
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       k_stop,
    input logic       ready,
    input logic       cq,
    input logic       rvalid,
    input logic       rd_busy,
    input logic       wr_busy,
    input logic [1:0] wr_beat
);
    logic [1:0] vcnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt_q <= '0;
        end else if (rvalid && !k_stop) begin
            vcnt_q <= vcnt_q + 1'b1;
        end
    end

    // R10
    stop_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        k_stop |=> !ready);

    // R10
    ready_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !k_stop |=> ready);

    // R10
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        k_stop |=> $stable(cq) && $stable(rvalid));

    // R10
    waking_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready && !rd_busy && !k_stop |=> !rd_busy);

    // R6
    echo_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !k_stop |=> cq != $past(cq));

    // R5
    four_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> vcnt_q == 2'd0);

    // R1
    wr_offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy && !k_stop && wr_beat != 2'd3 |=> wr_busy && wr_beat == $past(wr_beat) + 2'd1);
endmodule

bind qdr_burst_sram qdr_burst_sram_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .k_stop  (k_stop),
    .ready   (ready),
    .cq      (cq),
    .rvalid  (rvalid),
    .rd_busy (rd_busy),
    .wr_busy (wr_busy),
    .wr_beat (wr_beat)
);

// File: tb/qdr_burst_sram_tb.sv
`timescale 1ns/1ps
module qdr_burst_sram_tb;
    localparam int DW = 18, AW = 6, HALF_EXTRA = 0, RECOVER_K = 2048;
    localparam int LAT = 4 + HALF_EXTRA, WAKE = 2 * RECOVER_K;
    localparam int WORDS = 1 << AW, GROUPS = WORDS / 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, k_stop = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [AW-3:0] baddr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rvalid, cq, cq_n, ready;

    qdr_burst_sram #(.DW(DW), .AW(AW), .HALF_EXTRA(HALF_EXTRA), .RECOVER_K(RECOVER_K)) u_dut (
        .clk(clk), .rst_n(rst_n), .k_stop(k_stop), .rd_n(rd_n), .wr_n(wr_n),
        .baddr(baddr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .cq(cq), .cq_n(cq_n), .ready(ready)
    );

    int checks = 0, fails = 0;
    string tag = "R11";

    // bench model
    logic [DW-1:0] bmem [WORDS];
    int r_left = 0, w_left = 0, rec = WAKE, n = 0;
    logic [AW-3:0] rbase = '0, wbase = '0;
    bit kph = 1'b0;
    bit ev [int];
    logic [DW-1:0] ed [int];

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h (tick %0d)", t, act, exp, n);
        end
    endtask

    task automatic step(input logic rdn, input logic wrn, input logic [AW-3:0] a,
                        input logic [DW-1:0] wd, input logic stop);
        bit rdy;
        int idx;
        rd_n = rdn; wr_n = wrn; baddr = a; wdata = wd; k_stop = stop;
        @(posedge clk);
        #1;
        if (stop) begin
            rec = 0;
            check("R10 ready during stop", 32'(ready), 32'd0);
            return;
        end
        rdy = (rec == WAKE);
        if (r_left > 0) begin
            idx = 4 - r_left;
            ev[n + LAT - 1] = 1'b1;
            ed[n + LAT - 1] = bmem[{rbase, 2'(idx)}];
            r_left--;
        end
        if (w_left > 0) begin
            idx = 4 - w_left;
            bmem[{wbase, 2'(idx)}] = wd;
            w_left--;
        end
        if (rdy && !kph && !rdn && r_left == 0) begin r_left = 4; rbase = a; end
        if (rdy && kph && !wrn && w_left == 0) begin w_left = 4; wbase = a; end
        if (rec < WAKE) rec++;
        kph = !kph;
        check("R6 cq", 32'(cq), 32'(kph));
        check("R6 cq_n", 32'(cq_n), 32'(!kph));
        check("R5 rvalid", 32'(rvalid), 32'(ev.exists(n)));
        if (ev.exists(n)) check(tag, 32'(rdata), 32'(ed[n]));
        check("R10 ready", 32'(ready), 32'(rec == WAKE));
        n++;
    endtask

    task automatic idle();
        step(1'b1, 1'b1, '0, DW'($urandom), 1'b0);
    endtask
    task automatic align_k();
        if (kph) idle();
    endtask
    task automatic align_kb();
        if (!kph) idle();
    endtask
    task automatic wr_burst(input logic [AW-3:0] g, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                            input logic [DW-1:0] d2, input logic [DW-1:0] d3);
        align_kb();
        step(1'b1, 1'b0, g, '0, 1'b0);
        step(1'b1, 1'b1, '0, d0, 1'b0);
        step(1'b1, 1'b1, '0, d1, 1'b0);
        step(1'b1, 1'b1, '0, d2, 1'b0);
        step(1'b1, 1'b1, '0, d3, 1'b0);
    endtask
    task automatic rd_burst(input logic [AW-3:0] g);
        align_k();
        step(1'b0, 1'b1, g, '0, 1'b0);
        repeat (LAT + 5) idle();
    endtask

    bit done = 1'b0;
    initial begin
        #(100000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int k;
        int cnt;
        int b;
        k = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        check("R11 rvalid", 32'(rvalid), 32'd0);
        check("R11 ready", 32'(ready), 32'd1);
        check("R11 cq", 32'(cq), 32'd0);
        rst_n = 1'b1;

        // R3 / R7: fill every group with back-to-back write bursts
        tag = "R3/R7 fill";
        b = 0;
        while (b < GROUPS) begin
            if (kph && w_left <= 1) begin
                step(1'b1, 1'b0, (AW-2)'(b), DW'($urandom), 1'b0);
                b++;
            end else begin
                idle();
            end
        end
        repeat (6) idle();

        // R1 / R4: burst order and latency
        tag = "R1/R4 read";
        align_k();
        step(1'b0, 1'b1, 4'd5, '0, 1'b0);
        k = 0;
        do begin idle(); k++; end while (!rvalid && k < 20);
        check("R4 latency ticks", 32'(k), 32'(LAT));
        repeat (6) idle();

        // R2: selects on the wrong tick are ignored
        tag = "R2";
        align_k();
        step(1'b1, 1'b0, 4'd3, '0, 1'b0);
        repeat (4) step(1'b1, 1'b1, '0, 18'h15A5A, 1'b0);
        align_kb();
        step(1'b0, 1'b1, 4'd3, '0, 1'b0);
        cnt = 0;
        repeat (LAT + 4) begin idle(); if (rvalid) cnt++; end
        check("R2 no read beats", 32'(cnt), 32'd0);
        rd_burst(4'd3);

        // R9: read right after write to same group
        tag = "R9";
        align_kb();
        step(1'b1, 1'b0, 4'd7, '0, 1'b0);
        step(1'b0, 1'b1, 4'd7, 18'h01111, 1'b0);
        step(1'b1, 1'b1, '0, 18'h02222, 1'b0);
        step(1'b1, 1'b1, '0, 18'h03333, 1'b0);
        step(1'b1, 1'b1, '0, 18'h04444, 1'b0);
        repeat (LAT + 4) idle();

        // R8: overlapping read of same type is ignored
        tag = "R8";
        align_k();
        step(1'b0, 1'b1, 4'd9, '0, 1'b0);
        idle();
        step(1'b0, 1'b1, 4'd10, '0, 1'b0);
        cnt = 0;
        repeat (LAT + 8) begin idle(); if (rvalid) cnt++; end
        check("R8 beats", 32'(cnt), 32'd4);

        // R12: full-width patterns
        tag = "R12";
        wr_burst(4'd11, 18'h3FFFF, 18'h2AAAA, 18'h15555, 18'h00001);
        rd_burst(4'd11);

        // R7 / R8: random concurrent traffic
        tag = "R7/R8 random";
        repeat (3000) step(1'($urandom), 1'($urandom), (AW-2)'($urandom), DW'($urandom), 1'b0);
        repeat (LAT + 8) idle();

        // R10: clock stop and recovery
        tag = "R10";
        repeat (10) step(1'b1, 1'b1, '0, '0, 1'b1);
        k = 0;
        do begin
            step(1'b0, 1'b0, (AW-2)'($urandom), DW'($urandom), 1'b0);
            k++;
        end while (!ready && k < WAKE + 10);
        check("R10 recovery ticks", 32'(k), 32'(WAKE));
        repeat (LAT + 8) idle();
        for (int g = 0; g < 4; g++) rd_burst((AW-2)'(g));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule